// File: doc/BRIEF.md
# Two-Sample Packing Clock-Crossing FIFO

This block moves an unbroken stream of narrow samples from a fast producer clock into a slower consumer clock. The producer offers one sample per write-clock cycle and cannot be stalled. A single sample per read cycle would not keep up, so the block joins every two consecutive samples into one double-width word. That word is what crosses the clock boundary, which gives the read side enough bandwidth to drain the stream at its own rate.

Write and read clocks are unrelated. Each side keeps a binary pointer and a Gray-coded copy of it. The Gray copy reaches the other domain through a chain of two flip-flops. The full flag is derived in the write domain and the empty flag in the read domain, each from the local pointer and the synchronized far pointer. A pair that completes while the buffer is full is discarded, and a sticky overflow flag records the loss. Each domain releases its asynchronous active-low reset synchronously.

Top module: `sample_pair_fifo`

## Requirements
- R1: A stored word holds two consecutive input samples: the earlier one in bits [13:0] and the later one in bits [27:14].
- R2: A lone first sample of a pair is never visible to the reader; the FIFO stays empty until the second sample arrives.
- R3: Under a continuous write stream with the reader draining whenever not empty, every pair is delivered in arrival order with none lost and no overflow.
- R4: Once every stored word has been read, `rd_empty` is high. A read request while empty is ignored and moves no pointer.
- R5: `wr_full` rises once DEPTH pairs are stored and none have been read.
- R6: A pair completed while full is discarded, the stored contents are unchanged, and `wr_overflow` goes high and stays high.
- R7: `wr_overflow` is cleared only by reset.
- R8: Read data appears on `rd_word` on the read-clock cycle after `rd_en` is accepted with `rd_empty` low.
- R9: After reset, `rd_empty` is high and `wr_full` and `wr_overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sample (write) clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_valid | input | 1 | Sample strobe, one sample per asserted cycle |
| wr_sample | input | SAMPLE_W (14) | Input sample |
| wr_full | output | 1 | Buffer holds DEPTH pairs |
| wr_overflow | output | 1 | Sticky flag: a completed pair was dropped |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en | input | 1 | Read request |
| rd_word | output | 2*SAMPLE_W (28) | Registered pair, earlier sample in the low half |
| rd_empty | output | 1 | No complete pair is stored |

## Verification
The bench checks the half order of the packed word with samples whose halves are distinct, so a design that swaps the halves returns mirrored words. It holds a single sample for many read cycles to catch a packer that publishes half a pair. It fills the buffer exactly and then pushes one extra pair. A design with an off-by-one full test either overwrites the oldest word or loses the last good one, and one without a sticky flag lets the overflow indication fall. The streaming test runs both clocks together at full write rate, which exposes a broken Gray crossing or an empty flag computed one pointer wrong, since either one duplicates or skips words.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int unsigned SPF_SAMPLE_W = 14;
  localparam int unsigned SPF_DEPTH    = 16;
  localparam int unsigned SPF_SYNC_N   = 2;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } spf_phase_e;
endpackage

// File: rtl/spf_rst_sync.sv
module spf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/spf_sync.sv
module spf_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/spf_packer.sv
module spf_packer
  import spf_pkg::*;
#(
  parameter int unsigned SW = SPF_SAMPLE_W,
  localparam int unsigned PW = 2 * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_sample,
  output logic          pair_valid,
  output logic [PW-1:0] pair_data
);
  spf_phase_e    phase_q, phase_d;
  logic [SW-1:0] first_q, first_d;
  logic [PW-1:0] pair_q, pair_d;
  logic          vld_q, vld_d;

  always_comb begin
    phase_d = phase_q;
    first_d = first_q;
    pair_d  = pair_q;
    vld_d   = 1'b0;
    if (in_valid) begin
      if (phase_q == PH_FIRST) begin
        first_d = in_sample;
        phase_d = PH_SECOND;
      end else begin
        pair_d  = {in_sample, first_q};
        vld_d   = 1'b1;
        phase_d = PH_FIRST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      first_q <= '0;
      pair_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      first_q <= first_d;
      pair_q  <= pair_d;
      vld_q   <= vld_d;
    end
  end

  assign pair_valid = vld_q;
  assign pair_data  = pair_q;

  AST_PAIR_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(in_valid) && !$past(vld_q)); // R2
endmodule

// File: rtl/spf_wr_ctl.sv
module spf_wr_ctl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW:0]   rgray_sync,
  output logic          wen,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          overflow
);
  logic [AW:0] wbin_q, wbin_d;
  logic [AW:0] wgray_q, wgray_d;
  logic        full_q, full_d;
  logic        ovf_q, ovf_d;
  logic [AW:0] full_pattern;

  assign wen          = push && !full_q;
  assign full_pattern = {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]};

  always_comb begin
    wbin_d  = wbin_q + (AW+1)'(wen);
    wgray_d = wbin_d ^ (wbin_d >> 1);
    full_d  = (wgray_d == full_pattern);
    ovf_d   = ovf_q | (push & full_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      ovf_q   <= ovf_d;
    end
  end

  assign waddr    = wbin_q[AW-1:0];
  assign wgray    = wgray_q;
  assign full     = full_q;
  assign overflow = ovf_q;

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wbin_q != $past(wbin_q)) |-> !$past(full_q)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_q) |-> ovf_q); // R7
  AST_WGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1); // R3
endmodule

// File: rtl/spf_rd_ctl.sv
module spf_rd_ctl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW:0]   wgray_sync,
  output logic          fire,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty
);
  logic [AW:0] rbin_q, rbin_d;
  logic [AW:0] rgray_q, rgray_d;
  logic        empty_q, empty_d;

  assign fire = req && !empty_q;

  always_comb begin
    rbin_d  = rbin_q + (AW+1)'(fire);
    rgray_d = rbin_d ^ (rbin_d >> 1);
    empty_d = (rgray_d == wgray_sync);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      empty_q <= empty_d;
    end
  end

  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;
  assign empty = empty_q;

  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rbin_q != $past(rbin_q)) |-> !$past(empty_q)); // R4
  AST_RGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1); // R3
endmodule

// File: rtl/sample_pair_fifo.sv
module sample_pair_fifo
  import spf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SPF_SAMPLE_W,
  parameter int unsigned DEPTH    = SPF_DEPTH,
  parameter int unsigned SYNC_N   = SPF_SYNC_N,
  localparam int unsigned PW      = 2 * SAMPLE_W,
  localparam int unsigned AW      = $clog2(DEPTH)
) (
  input  logic                wr_clk,
  input  logic                wr_rst_n,
  input  logic                wr_valid,
  input  logic [SAMPLE_W-1:0] wr_sample,
  output logic                wr_full,
  output logic                wr_overflow,
  input  logic                rd_clk,
  input  logic                rd_rst_n,
  input  logic                rd_en,
  output logic [PW-1:0]       rd_word,
  output logic                rd_empty
);
  logic          wrst_n, rrst_n;
  logic          pair_vld;
  logic [PW-1:0] pair_dat;
  logic          wen, rfire;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [PW-1:0] mem [DEPTH];
  logic [PW-1:0] rdata_q;

  spf_rst_sync #(.STAGES(SYNC_N)) u_wrst (.clk(wr_clk), .arst_n(wr_rst_n), .rst_n(wrst_n));
  spf_rst_sync #(.STAGES(SYNC_N)) u_rrst (.clk(rd_clk), .arst_n(rd_rst_n), .rst_n(rrst_n));

  spf_packer #(.SW(SAMPLE_W)) u_pack (
    .clk(wr_clk), .rst_n(wrst_n), .in_valid(wr_valid), .in_sample(wr_sample),
    .pair_valid(pair_vld), .pair_data(pair_dat));

  spf_wr_ctl #(.AW(AW)) u_wctl (
    .clk(wr_clk), .rst_n(wrst_n), .push(pair_vld), .rgray_sync(rgray_s),
    .wen(wen), .waddr(waddr), .wgray(wgray), .full(wr_full), .overflow(wr_overflow));

  spf_rd_ctl #(.AW(AW)) u_rctl (
    .clk(rd_clk), .rst_n(rrst_n), .req(rd_en), .wgray_sync(wgray_s),
    .fire(rfire), .raddr(raddr), .rgray(rgray), .empty(rd_empty));

  spf_sync #(.W(AW+1), .STAGES(SYNC_N)) u_w2r (
    .clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  spf_sync #(.W(AW+1), .STAGES(SYNC_N)) u_r2w (
    .clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  always_ff @(posedge wr_clk) begin
    if (wen) mem[waddr] <= pair_dat;
  end

  always_ff @(posedge rd_clk or negedge rrst_n) begin
    if (!rrst_n)    rdata_q <= '0;
    else if (rfire) rdata_q <= mem[raddr];
  end

  assign rd_word = rdata_q;

  initial begin
    AST_DEPTH_POW2: assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0); // R5
  end
endmodule

// File: tb/tb_sample_pair_fifo.sv
module tb_sample_pair_fifo;
  localparam int SW = 14;
  localparam int DEPTH = 16;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_valid = 0;
  logic [SW-1:0] wr_sample = '0;
  logic rd_en = 0;
  logic wr_full, wr_overflow, rd_empty;
  logic [2*SW-1:0] rd_word;

  int checks = 0, errors = 0, cyc = 0;

  always #10 wr_clk = ~wr_clk;
  always #15 rd_clk = ~rd_clk;

  sample_pair_fifo #(.SAMPLE_W(SW), .DEPTH(DEPTH)) dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_sample(wr_sample),
    .wr_full(wr_full), .wr_overflow(wr_overflow),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_word(rd_word), .rd_empty(rd_empty));

  function automatic logic [SW-1:0] smp(int seed, int i);
    return SW'((i * 173 + seed * 911 + 7) ^ (i << 9));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge wr_clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge wr_clk); wr_rst_n = 0; rd_rst_n = 0; wr_valid = 0; rd_en = 0;
    repeat (3) @(negedge rd_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (6) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic settle();
    repeat (10) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic put(logic [SW-1:0] v);
    wr_valid = 1; wr_sample = v;
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic get(output logic [2*SW-1:0] w, output bit ok);
    @(negedge rd_clk);
    if (rd_empty) begin ok = 0; w = '0; return; end
    rd_en = 1;
    @(negedge rd_clk);
    rd_en = 0;
    w = rd_word; ok = 1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(rd_empty === 1'b1, "R9 empty", 32'(rd_empty), 1);
    chk(wr_full === 1'b0, "R9 full", 32'(wr_full), 0);
    chk(wr_overflow === 1'b0, "R9 overflow", 32'(wr_overflow), 0);
  endtask

  task automatic t_pack_order();
    logic [2*SW-1:0] w; bit ok;
    put(14'h0155); put(14'h2AAA); put(14'h3C0F); put(14'h00F3);
    settle();
    get(w, ok);
    chk(ok && w == {14'h2AAA, 14'h0155}, "R1 R8 first word", 32'(w), 32'({14'h2AAA, 14'h0155}));
    get(w, ok);
    chk(ok && w == {14'h00F3, 14'h3C0F}, "R1 second word", 32'(w), 32'({14'h00F3, 14'h3C0F}));
    repeat (4) @(negedge rd_clk);
    chk(rd_empty === 1'b1, "R4 empty after drain", 32'(rd_empty), 1);
  endtask

  task automatic t_half_pair();
    logic [2*SW-1:0] w; bit ok;
    put(14'h1234);
    settle(); settle();
    chk(rd_empty === 1'b1, "R2 half pair hidden", 32'(rd_empty), 1);
    @(negedge rd_clk); rd_en = 1;
    repeat (3) @(negedge rd_clk); rd_en = 0;
    chk(rd_empty === 1'b1, "R4 read while empty", 32'(rd_empty), 1);
    @(negedge wr_clk);
    put(14'h0ABC);
    settle();
    chk(rd_empty === 1'b0, "R2 pair visible", 32'(rd_empty), 0);
    get(w, ok);
    chk(ok && w == {14'h0ABC, 14'h1234}, "R4 ignored read kept pointer", 32'(w), 32'({14'h0ABC, 14'h1234}));
  endtask

  task automatic t_fill_overflow();
    logic [2*SW-1:0] w; bit ok; int bad;
    for (int i = 0; i < 2 * DEPTH - 2; i++) put(smp(3, i));
    settle();
    chk(wr_full === 1'b0, "R5 not full at DEPTH-1", 32'(wr_full), 0);
    put(smp(3, 2 * DEPTH - 2)); put(smp(3, 2 * DEPTH - 1));
    settle();
    chk(wr_full === 1'b1, "R5 full at DEPTH", 32'(wr_full), 1);
    chk(wr_overflow === 1'b0, "R6 no overflow yet", 32'(wr_overflow), 0);
    put(14'h3FFF); put(14'h3FFE);
    settle();
    chk(wr_overflow === 1'b1, "R6 overflow set", 32'(wr_overflow), 1);
    bad = 0;
    for (int k = 0; k < DEPTH; k++) begin
      get(w, ok);
      if (!ok || w != {smp(3, 2*k+1), smp(3, 2*k)}) begin
        bad++;
        chk(0, "R6 stored word", 32'(w), 32'({smp(3, 2*k+1), smp(3, 2*k)}));
      end
    end
    chk(bad == 0, "R6 contents intact", 32'(bad), 0);
    repeat (4) @(negedge rd_clk);
    chk(rd_empty === 1'b1, "R6 dropped pair absent", 32'(rd_empty), 1);
    settle();
    chk(wr_overflow === 1'b1, "R7 overflow sticky", 32'(wr_overflow), 1);
    chk(wr_full === 1'b0, "R5 full clears after drain", 32'(wr_full), 0);
    do_reset();
    chk(wr_overflow === 1'b0, "R7 reset clears overflow", 32'(wr_overflow), 0);
  endtask

  task automatic t_stream();
    int got = 0, bad = 0, guard = 0;
    bit pend = 0;
    localparam int NW = 300;
    fork
      begin
        for (int i = 0; i < 2 * NW; i++) put(smp(7, i));
      end
      begin
        while (got < NW && guard < 20000) begin
          @(negedge rd_clk);
          guard++;
          if (pend) begin
            if (rd_word != {smp(7, 2*got+1), smp(7, 2*got)}) begin
              bad++;
              chk(0, "R3 stream word", 32'(rd_word), 32'({smp(7, 2*got+1), smp(7, 2*got)}));
            end
            got++;
          end
          rd_en = !rd_empty && (got + 32'(!rd_empty && 1'b0) < NW) && (got + (pend ? 0 : 0) < NW);
          if (pend && got >= NW) rd_en = 0;
          pend = rd_en;
        end
        rd_en = 0;
      end
    join
    chk(got == NW, "R3 all words received", 32'(got), NW);
    chk(bad == 0, "R3 order preserved", 32'(bad), 0);
    chk(wr_overflow === 1'b0, "R3 no overflow", 32'(wr_overflow), 0);
    repeat (4) @(negedge rd_clk);
    chk(rd_empty === 1'b1, "R4 empty at end", 32'(rd_empty), 1);
  endtask

  initial begin
    t_reset_state();
    t_pack_order();
    t_half_pair();
    do_reset();
    t_fill_overflow();
    t_stream();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule